// File: doc/BRIEF.md
# Shared Root-Port Ownership Router

This block sits between a group of root-hub ports and two host controllers that share them: one high-speed (enhanced) controller and a full/low-speed companion. Each port is shown to exactly one of the two controllers at a time. The block passes that port's line state and connect status to its owner. To the other controller the port looks empty.

Ownership is set by a global configure flag and a per-port owner bit.
- While the flag is clear, every port goes to the companion.
- While the flag is set, a port goes to the enhanced side unless its owner bit is 1.

Writing an owner bit while a device is attached hands the port over. The receiving controller sees a fresh connect and the releasing one sees a disconnect.

The flag and the owner bits live in an always-on domain with their own reset. The connect, enable and event state lives in the core domain. A core reset therefore leaves the routing untouched, and ports need no remapping after a sleep.

Top module: `usb_port_router`

## Requirements
- R1: With the configure flag at 0, every port is companion-owned: the companion sees the connect (level and one-cycle event) and the enhanced connect, enable and event outputs stay 0.
- R2: With the flag at 1 and an owner bit of 0 (0 = enhanced, 1 = companion), a device attach gives the enhanced side a one-cycle connect event and a connect level, and the companion sees the port as unconnected.
- R3: With the flag at 1, writing 1 to the owner bit of a port with a device attached gives a one-cycle companion connect event and a one-cycle enhanced disconnect event in the same cycle, one cycle after the owner bit changes.
- R4: A port-reset-done pulse on an enhanced-owned connected port sets the enable bit when the high-speed-ok input is 1 and leaves it 0 otherwise. Enable drops whenever the enhanced side loses the connect.
- R5: The 2-bit line state of port i (bits 2i+1:2i) is passed to the controller that owns the port. The other controller's line output for that port reads 0.
- R6: With the flag at 1, a device leaving a companion-owned port clears that owner bit by itself, on the same edge that the companion disconnect event appears. The enhanced side gets no event from it.
- R7: With the flag at 1, a device leaving an enhanced-owned port gives an enhanced disconnect event, leaves the owner bit at 0 and gives the companion no event.
- R8: The core reset clears the connect views, enable, status-change and event outputs, and leaves the configure flag and owner bits unchanged.
- R9: The always-on reset clears the configure flag and all owner bits.
- R10: An owner-bit write on a port with no device attached changes the owner and produces no event toward either controller.
- R11: A configure-flag write that takes the flag from 0 to 1 clears every owner bit. This takes priority over an owner write on the same edge.
- R12: The enhanced status-change bit of a port is set on any change of its enhanced connect view and cleared by a write-1 strobe. Setting wins over clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| aon_rst | input | 1 | Always-on synchronous reset, active high |
| core_rst | input | 1 | Core-domain synchronous reset, active high |
| cfg_wr | input | 1 | Configure-flag write strobe |
| cfg_wdata | input | 1 | Configure-flag write value |
| own_wr | input | NUM_PORTS | Per-port owner-bit write strobes |
| own_wdata | input | NUM_PORTS | Owner-bit write values (1 = companion) |
| csc_clr | input | NUM_PORTS | Write-1 clear of the enhanced status-change bits |
| phy_conn | input | NUM_PORTS | Physical connect status per port |
| phy_line | input | 2*NUM_PORTS | Line state per port, 2 bits each |
| prst_done | input | NUM_PORTS | Port-reset-complete pulse per port |
| hs_ok | input | NUM_PORTS | High-speed handshake completed, valid with prst_done |
| cfg_flag | output | 1 | Current configure flag |
| owner | output | NUM_PORTS | Current owner bits |
| enh_conn | output | NUM_PORTS | Enhanced-side connect status |
| enh_en | output | NUM_PORTS | Enhanced-side port enable |
| enh_csc | output | NUM_PORTS | Enhanced-side connect status change |
| enh_line | output | 2*NUM_PORTS | Line state routed to the enhanced side |
| enh_conn_ev | output | NUM_PORTS | Enhanced connect event pulse |
| enh_disc_ev | output | NUM_PORTS | Enhanced disconnect event pulse |
| cmp_conn | output | NUM_PORTS | Companion-side connect status |
| cmp_line | output | 2*NUM_PORTS | Line state routed to the companion |
| cmp_conn_ev | output | NUM_PORTS | Companion connect event pulse |
| cmp_disc_ev | output | NUM_PORTS | Companion disconnect event pulse |

## Verification
A handoff with a device attached must produce a paired event, a companion connect together with an enhanced disconnect. A design that routes the level without tracking the previous view would drop one of the two pulses. An owner write on an empty port must stay silent, where a design that derives events from owner changes would emit phantom connects. A companion-side disconnect must hand the empty port back by itself, or the port stays stranded on the companion side. A core reset must leave the flag and owner bits intact; a design that tied both domains to one reset would lose the routing.

// File: rtl/usb_route_pkg.sv
package usb_route_pkg;

    localparam int LINE_W = 2;

    typedef enum logic {
        OWN_ENH = 1'b0,
        OWN_CMP = 1'b1
    } owner_e;

    typedef struct packed {
        logic enh_conn;
        logic cmp_conn;
        logic enh_en;
        logic enh_csc;
    } slot_state_t;

    typedef struct packed {
        logic enh_conn;
        logic enh_disc;
        logic cmp_conn;
        logic cmp_disc;
    } slot_evt_t;

    function automatic owner_e eff_owner(input logic cfg, input logic own_bit);
        return (!cfg || own_bit) ? OWN_CMP : OWN_ENH;
    endfunction

endpackage

// File: rtl/usb_route_owner.sv
module usb_route_owner #(
    parameter int NUM_PORTS = 4
) (
    input  logic                 clk,
    input  logic                 aon_rst,
    input  logic                 core_rst,
    input  logic                 cfg_wr_i,
    input  logic                 cfg_wdata_i,
    input  logic [NUM_PORTS-1:0] own_wr_i,
    input  logic [NUM_PORTS-1:0] own_wdata_i,
    input  logic [NUM_PORTS-1:0] cmp_gone_i,
    output logic                 cfg_o,
    output logic [NUM_PORTS-1:0] own_o
);

    logic                 cfg_q;
    logic [NUM_PORTS-1:0] own_q;
    logic                 cfg_rise;

    assign cfg_rise = cfg_wr_i && cfg_wdata_i && !cfg_q;

    always_ff @(posedge clk) begin
        if (aon_rst) begin
            cfg_q <= 1'b0;
            own_q <= '0;
        end else begin
            if (cfg_wr_i) begin
                cfg_q <= cfg_wdata_i;
            end
            if (cfg_rise) begin
                own_q <= '0;
            end else begin
                for (int i = 0; i < NUM_PORTS; i++) begin
                    if (own_wr_i[i]) begin
                        own_q[i] <= own_wdata_i[i];
                    end else if (cfg_q && cmp_gone_i[i]) begin
                        own_q[i] <= 1'b0;
                    end
                end
            end
        end
    end

    assign cfg_o = cfg_q;
    assign own_o = own_q;

    // R11: flag rising from 0 leaves every port enhanced-owned
    a_r11_rise_clears_owner: assert property (@(posedge clk) disable iff (aon_rst)
        $rose(cfg_q) |-> (own_q == '0));

    // R6: a companion-side departure returns the port to the enhanced side
    a_r6_auto_return: assert property (@(posedge clk) disable iff (aon_rst)
        cfg_q |=> ((own_q & $past(cmp_gone_i & ~own_wr_i)) == '0));

    // R8: the core reset alone does not disturb the routing state
    a_r8_core_rst_keeps_route: assert property (@(posedge clk) disable iff (aon_rst)
        (core_rst && !cfg_wr_i && (own_wr_i == '0)) |=> ($stable(cfg_q) && $stable(own_q)));

endmodule

// File: rtl/usb_route_slot.sv
module usb_route_slot
    import usb_route_pkg::*;
(
    input  logic              clk,
    input  logic              core_rst,
    input  logic              cfg_i,
    input  logic              own_i,
    input  logic              phy_conn_i,
    input  logic [LINE_W-1:0] phy_line_i,
    input  logic              prst_done_i,
    input  logic              hs_ok_i,
    input  logic              csc_clr_i,
    output slot_state_t       state_o,
    output slot_evt_t         evt_o,
    output logic [LINE_W-1:0] enh_line_o,
    output logic [LINE_W-1:0] cmp_line_o,
    output logic              cmp_gone_o
);

    owner_e      who;
    logic        enh_view;
    logic        cmp_view;
    slot_state_t st_q;
    slot_evt_t   ev_q;

    assign who      = eff_owner(cfg_i, own_i);
    assign enh_view = phy_conn_i && (who == OWN_ENH);
    assign cmp_view = phy_conn_i && (who == OWN_CMP);

    always_ff @(posedge clk) begin
        if (core_rst) begin
            st_q <= '0;
            ev_q <= '0;
        end else begin
            st_q.enh_conn <= enh_view;
            st_q.cmp_conn <= cmp_view;
            ev_q.enh_conn <= enh_view && !st_q.enh_conn;
            ev_q.enh_disc <= !enh_view && st_q.enh_conn;
            ev_q.cmp_conn <= cmp_view && !st_q.cmp_conn;
            ev_q.cmp_disc <= !cmp_view && st_q.cmp_conn;
            if (!enh_view) begin
                st_q.enh_en <= 1'b0;
            end else if (prst_done_i) begin
                st_q.enh_en <= hs_ok_i;
            end
            if (enh_view != st_q.enh_conn) begin
                st_q.enh_csc <= 1'b1;
            end else if (csc_clr_i) begin
                st_q.enh_csc <= 1'b0;
            end
        end
    end

    assign state_o    = st_q;
    assign evt_o      = ev_q;
    assign enh_line_o = (who == OWN_ENH) ? phy_line_i : '0;
    assign cmp_line_o = (who == OWN_CMP) ? phy_line_i : '0;
    assign cmp_gone_o = st_q.cmp_conn && !phy_conn_i;

    // R1: flag clear keeps the enhanced side blind
    a_r1_flag0_no_enh: assert property (@(posedge clk) disable iff (core_rst)
        !cfg_i |=> (!st_q.enh_conn && !ev_q.enh_conn));

    // R2: a connected port is never seen by both controllers
    a_r2_single_owner: assert property (@(posedge clk) disable iff (core_rst)
        !(st_q.enh_conn && st_q.cmp_conn));

    // R4: enable only on an enhanced-connected port
    a_r4_en_needs_conn: assert property (@(posedge clk) disable iff (core_rst)
        st_q.enh_en |-> st_q.enh_conn);

    // R3: events last a single cycle
    a_r3_event_pulse: assert property (@(posedge clk) disable iff (core_rst)
        (ev_q.enh_conn || ev_q.cmp_conn) |=> (!ev_q.enh_conn && !ev_q.cmp_conn));

endmodule

// File: rtl/usb_port_router.sv
module usb_port_router
    import usb_route_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic                          clk,
    input  logic                          aon_rst,
    input  logic                          core_rst,
    input  logic                          cfg_wr,
    input  logic                          cfg_wdata,
    input  logic [NUM_PORTS-1:0]          own_wr,
    input  logic [NUM_PORTS-1:0]          own_wdata,
    input  logic [NUM_PORTS-1:0]          csc_clr,
    input  logic [NUM_PORTS-1:0]          phy_conn,
    input  logic [LINE_W*NUM_PORTS-1:0]   phy_line,
    input  logic [NUM_PORTS-1:0]          prst_done,
    input  logic [NUM_PORTS-1:0]          hs_ok,
    output logic                          cfg_flag,
    output logic [NUM_PORTS-1:0]          owner,
    output logic [NUM_PORTS-1:0]          enh_conn,
    output logic [NUM_PORTS-1:0]          enh_en,
    output logic [NUM_PORTS-1:0]          enh_csc,
    output logic [LINE_W*NUM_PORTS-1:0]   enh_line,
    output logic [NUM_PORTS-1:0]          enh_conn_ev,
    output logic [NUM_PORTS-1:0]          enh_disc_ev,
    output logic [NUM_PORTS-1:0]          cmp_conn,
    output logic [LINE_W*NUM_PORTS-1:0]   cmp_line,
    output logic [NUM_PORTS-1:0]          cmp_conn_ev,
    output logic [NUM_PORTS-1:0]          cmp_disc_ev
);

    logic [NUM_PORTS-1:0] cmp_gone;
    logic                 cfg_w;
    logic [NUM_PORTS-1:0] own_w;

    usb_route_owner #(.NUM_PORTS(NUM_PORTS)) owner_i (
        .clk        (clk),
        .aon_rst    (aon_rst),
        .core_rst   (core_rst),
        .cfg_wr_i   (cfg_wr),
        .cfg_wdata_i(cfg_wdata),
        .own_wr_i   (own_wr),
        .own_wdata_i(own_wdata),
        .cmp_gone_i (cmp_gone),
        .cfg_o      (cfg_w),
        .own_o      (own_w)
    );

    assign cfg_flag = cfg_w;
    assign owner    = own_w;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_slot
        slot_state_t st;
        slot_evt_t   ev;

        usb_route_slot slot_i (
            .clk        (clk),
            .core_rst   (core_rst),
            .cfg_i      (cfg_w),
            .own_i      (own_w[p]),
            .phy_conn_i (phy_conn[p]),
            .phy_line_i (phy_line[LINE_W*p +: LINE_W]),
            .prst_done_i(prst_done[p]),
            .hs_ok_i    (hs_ok[p]),
            .csc_clr_i  (csc_clr[p]),
            .state_o    (st),
            .evt_o      (ev),
            .enh_line_o (enh_line[LINE_W*p +: LINE_W]),
            .cmp_line_o (cmp_line[LINE_W*p +: LINE_W]),
            .cmp_gone_o (cmp_gone[p])
        );

        assign enh_conn[p]    = st.enh_conn;
        assign enh_en[p]      = st.enh_en;
        assign enh_csc[p]     = st.enh_csc;
        assign cmp_conn[p]    = st.cmp_conn;
        assign enh_conn_ev[p] = ev.enh_conn;
        assign enh_disc_ev[p] = ev.enh_disc;
        assign cmp_conn_ev[p] = ev.cmp_conn;
        assign cmp_disc_ev[p] = ev.cmp_disc;
    end

endmodule

// File: tb/usb_port_router_tb.sv
module usb_port_router_tb_top;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         aon_rst, core_rst, cfg_wr, cfg_wdata;
    logic [N-1:0] own_wr, own_wdata, csc_clr, phy_conn, prst_done, hs_ok;
    logic [2*N-1:0] phy_line;
    logic         cfg_flag;
    logic [N-1:0] owner, enh_conn, enh_en, enh_csc, enh_conn_ev, enh_disc_ev;
    logic [N-1:0] cmp_conn, cmp_conn_ev, cmp_disc_ev;
    logic [2*N-1:0] enh_line, cmp_line;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    usb_port_router #(.NUM_PORTS(N)) dut_i (
        .clk(clk), .aon_rst(aon_rst), .core_rst(core_rst),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .own_wr(own_wr), .own_wdata(own_wdata), .csc_clr(csc_clr),
        .phy_conn(phy_conn), .phy_line(phy_line),
        .prst_done(prst_done), .hs_ok(hs_ok),
        .cfg_flag(cfg_flag), .owner(owner),
        .enh_conn(enh_conn), .enh_en(enh_en), .enh_csc(enh_csc),
        .enh_line(enh_line), .enh_conn_ev(enh_conn_ev), .enh_disc_ev(enh_disc_ev),
        .cmp_conn(cmp_conn), .cmp_line(cmp_line),
        .cmp_conn_ev(cmp_conn_ev), .cmp_disc_ev(cmp_disc_ev)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock edge, then settle away from it
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        aon_rst = 1; core_rst = 1; cfg_wr = 0; cfg_wdata = 0;
        own_wr = '0; own_wdata = '0; csc_clr = '0; phy_conn = '0;
        phy_line = '0; prst_done = '0; hs_ok = '0;
        step(); step();
        aon_rst = 0; core_rst = 0;
        step();
        chk("R9 flag after reset", cfg_flag, 0);
        chk("R9 owner after reset", owner, 0);
        chk("R8 views after reset", {enh_conn, cmp_conn, enh_en, enh_csc}, 0);
    endtask

    task automatic t_flag_clear();
        phy_conn[0] = 1; phy_line[1:0] = 2'b01;
        step();
        chk("R1 companion connect event", cmp_conn_ev[0], 1);
        chk("R1 companion connect level", cmp_conn[0], 1);
        chk("R1 enhanced blind", {enh_conn[0], enh_conn_ev[0], enh_en[0]}, 0);
        chk("R5 line to companion", cmp_line[1:0], 2'b01);
        chk("R5 line hidden from enhanced", enh_line[1:0], 0);
        step();
        chk("R1 event one cycle", cmp_conn_ev[0], 0);
        phy_conn[0] = 0; phy_line[1:0] = 2'b00;
        step();
        chk("R1 companion disconnect event", cmp_disc_ev[0], 1);
        step();
    endtask

    task automatic t_flag_rise();
        own_wr = '1; own_wdata = '1;
        step();
        own_wr = '0;
        chk("R11 owners written", owner, 4'hF);
        cfg_wr = 1; cfg_wdata = 1; own_wr[0] = 1; own_wdata[0] = 1;
        step();
        cfg_wr = 0; own_wr = '0;
        chk("R11 flag set", cfg_flag, 1);
        chk("R11 rise clears owners", owner, 0);
        step();
    endtask

    task automatic t_enh_attach();
        phy_conn[1] = 1;
        step();
        chk("R2 enhanced connect event", enh_conn_ev[1], 1);
        chk("R2 enhanced connect level", enh_conn[1], 1);
        chk("R2 companion sees nothing", {cmp_conn[1], cmp_conn_ev[1]}, 0);
        chk("R12 status change set", enh_csc[1], 1);
        step();
        chk("R2 event one cycle", enh_conn_ev[1], 0);
        chk("R12 status change holds", enh_csc[1], 1);
        csc_clr[1] = 1;
        step();
        csc_clr[1] = 0;
        chk("R12 write-1 clears", enh_csc[1], 0);
    endtask

    task automatic t_port_reset();
        prst_done[1] = 1; hs_ok[1] = 1;
        step();
        prst_done[1] = 0; hs_ok[1] = 0;
        chk("R4 high-speed enables", enh_en[1], 1);
        phy_conn[2] = 1; phy_line[5:4] = 2'b10;
        step(); step();
        chk("R5 line to enhanced", enh_line[5:4], 2'b10);
        chk("R5 line hidden from companion", cmp_line[5:4], 0);
        prst_done[2] = 1; hs_ok[2] = 0;
        step();
        prst_done[2] = 0;
        chk("R4 non-high-speed stays disabled", enh_en[2], 0);
    endtask

    task automatic t_handoff();
        own_wr[2] = 1; own_wdata[2] = 1;
        step();
        own_wr[2] = 0;
        chk("R3 owner bit set", owner[2], 1);
        step();
        chk("R3 companion connect event", cmp_conn_ev[2], 1);
        chk("R3 enhanced disconnect event", enh_disc_ev[2], 1);
        chk("R3 levels swap", {enh_conn[2], cmp_conn[2]}, 2'b01);
        chk("R5 line follows owner", {enh_line[5:4], cmp_line[5:4]}, 4'b0010);
        step();
        chk("R3 events one cycle", {cmp_conn_ev[2], enh_disc_ev[2]}, 0);
    endtask

    task automatic t_cmp_leave();
        phy_conn[2] = 0; phy_line[5:4] = 0;
        step();
        chk("R6 companion disconnect event", cmp_disc_ev[2], 1);
        chk("R6 owner auto-cleared", owner[2], 0);
        chk("R6 no enhanced event", {enh_conn_ev[2], enh_disc_ev[2]}, 0);
        step();
        chk("R6 no enhanced event later", {enh_conn_ev[2], enh_disc_ev[2], enh_conn[2]}, 0);
    endtask

    task automatic t_enh_leave();
        phy_conn[1] = 0;
        step();
        chk("R7 enhanced disconnect event", enh_disc_ev[1], 1);
        chk("R7 owner unchanged", owner[1], 0);
        chk("R7 companion no event", {cmp_conn_ev[1], cmp_disc_ev[1]}, 0);
        chk("R4 enable drops on disconnect", enh_en[1], 0);
        step();
    endtask

    task automatic t_empty_write();
        own_wr[3] = 1; own_wdata[3] = 1;
        step();
        own_wr[3] = 0;
        chk("R10 owner changed", owner[3], 1);
        step();
        chk("R10 no events", {enh_conn_ev[3], enh_disc_ev[3], cmp_conn_ev[3], cmp_disc_ev[3]}, 0);
        step();
        chk("R10 still no events", {enh_conn_ev[3], enh_disc_ev[3], cmp_conn_ev[3], cmp_disc_ev[3], cmp_conn[3]}, 0);
    endtask

    task automatic t_core_reset();
        phy_conn[0] = 1;
        step(); step();
        prst_done[0] = 1; hs_ok[0] = 1;
        step();
        prst_done[0] = 0; hs_ok[0] = 0;
        chk("R4 enabled before core reset", enh_en[0], 1);
        core_rst = 1;
        step();
        core_rst = 0;
        chk("R8 flag kept", cfg_flag, 1);
        chk("R8 owners kept", owner, 4'b1000);
        chk("R8 core state cleared", {enh_conn, enh_en, enh_csc}, 0);
        step();
    endtask

    task automatic t_aon_reset();
        aon_rst = 1;
        step();
        aon_rst = 0;
        chk("R9 flag cleared", cfg_flag, 0);
        chk("R9 owners cleared", owner, 0);
    endtask

    initial begin
        t_reset();
        t_flag_clear();
        t_flag_rise();
        t_enh_attach();
        t_port_reset();
        t_handoff();
        t_cmp_leave();
        t_enh_leave();
        t_empty_write();
        t_core_reset();
        t_aon_reset();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule